// File: doc/BRIEF.md
# Priority-Ceiling Interrupt Controller

This block arbitrates the interrupt sources of one processor and raises a single request line only when the best pending source outranks a software-controlled current level. It has 32 sources. The low eight are flags that software sets and clears. The upper 24 follow peripheral request lines, so peripheral line n appears as source (and vector) n + 8. Each source carries a 4-bit priority, and priority 0 means the source is never serviced.

When the processor acknowledges, the block hands back the winning source number. It saves the level in force on an internal last-in-first-out store and lifts the current level to the winner's priority. An end-of-interrupt strobe restores the saved level. Software may also write the current level directly, for example to lift it to the ceiling of all handlers that share a resource. Sources at or below that ceiling are then held off, while sources above it can still preempt.

Top module: `prio_ceiling_intc`

## Requirements
- R1: After a synchronous reset, `irq_out`, `ack_valid`, `ack_vec`, `eoi_err` and `cur_level` are all 0. All priorities and software flags are 0, and the save store is empty.
- R2: `irq_out` is high one cycle after the inputs exactly when some pending source with a nonzero priority has a priority strictly above the current level. A pending source with priority 0 never raises it.
- R3: An acknowledge that is taken sets `ack_valid` and returns in `ack_vec` the number of the highest-priority pending source above the level. On a tie the lowest number wins. Software flag k is number k, and peripheral line n is number n + 8. In every other cycle `ack_vec` is 0.
- R4: A taken acknowledge saves the level in force and sets `cur_level` to the winner's priority. An acknowledge with no source above the level leaves the level and the store unchanged, with `ack_valid` low.
- R5: Each `eoi` pulse restores the most recently saved level, in last-in-first-out order.
- R6: An `eoi` with an empty store changes nothing else. It sets `eoi_err`, which stays set until reset.
- R7: A write of the current level sets `cur_level` to the written value. Sources at or below it are held off, and sources above it still raise `irq_out`.
- R8: A level write takes effect before arbitration in the same cycle. A source that arrives in the same cycle as a write that puts the level at or above it does not raise `irq_out`. A write that puts the level above every pending source drops `irq_out` in the next cycle.
- R9: A flag write sets the flags in `swflag_set` and clears those in `swflag_clr`, and set wins on the same bit. Peripheral lines are level-sensitive and are pending only while high. A priority write takes effect in arbitration from the next cycle.
- R10: The store holds 16 levels. An acknowledge while it is full is refused: `ack_valid` stays low and the level is unchanged.
- R11: An `eoi` in the same cycle as `ack` is ignored. It neither restores a level nor flags an error.
- R12: When a level write and an acknowledge share a cycle, the saved level is the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prio_wr_en | input | 1 | Write a source priority |
| prio_wr_src | input | 5 | Source number for a priority write |
| prio_wr_level | input | 4 | Priority value to write |
| swflag_wr_en | input | 1 | Update the software flags |
| swflag_set | input | 8 | Flags to set |
| swflag_clr | input | 8 | Flags to clear |
| periph_req | input | 24 | Level-sensitive peripheral requests |
| ceil_wr_en | input | 1 | Write the current level |
| ceil_wr_level | input | 4 | New current level |
| ack | input | 1 | Processor acknowledge strobe |
| eoi | input | 1 | End-of-interrupt strobe |
| irq_out | output | 1 | Request to the processor |
| ack_valid | output | 1 | An acknowledge was taken |
| ack_vec | output | 5 | Vector of the acknowledged source |
| cur_level | output | 4 | Current priority level |
| eoi_err | output | 1 | Sticky end-of-interrupt underflow flag |

## Verification
Every output is a register, and each is updated at the first clock edge after the inputs that cause it. A level change, a new flag or a new peripheral line therefore shows on `irq_out` one edge later, with no extra stage. The bench drives each stimulus at the falling edge. It works out the expected values before the next rising edge and compares them 5 ns after that edge, which is one edge per step and exactly where the registered result is due. Directed steps cover ties, same-cycle level writes, acknowledge with end-of-interrupt, and a full and an empty store. Seeded random traffic then exercises the mix of all of these.

// File: rtl/pcic_pkg.sv
package pcic_pkg;
  // What the current level does in a cycle, after any software write
  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_TAKE = 2'd1,
    OP_POP  = 2'd2,
    OP_ERR  = 2'd3
  } cur_op_e;
endpackage

// File: rtl/pcic_src_regs.sv
module pcic_src_regs #(
  parameter int NSW    = 8,
  parameter int NPER   = 24,
  parameter int PRIO_W = 4,
  localparam int NSRC  = NSW + NPER,
  localparam int IDX_W = $clog2(NSRC)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   prio_we,
  input  logic [IDX_W-1:0]       prio_idx,
  input  logic [PRIO_W-1:0]      prio_wdata,
  input  logic                   sw_we,
  input  logic [NSW-1:0]         sw_set,
  input  logic [NSW-1:0]         sw_clr,
  input  logic [NPER-1:0]        periph_req,
  output logic [NSRC-1:0]        pend_nx,
  output logic [NSRC*PRIO_W-1:0] prio_flat
);
  logic [PRIO_W-1:0] prio_tab [NSRC];
  logic [NSW-1:0]    sw_q;
  logic [NSW-1:0]    sw_nx;

  always_comb begin
    sw_nx = sw_we ? ((sw_q & ~sw_clr) | sw_set) : sw_q;
  end

  always_ff @(posedge clk) begin
    if (rst) sw_q <= '0;
    else     sw_q <= sw_nx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NSRC; i++) prio_tab[i] <= '0;
    end else if (prio_we && (int'(prio_idx) < NSRC)) begin
      prio_tab[prio_idx] <= prio_wdata;
    end
  end

  // Arbitration sees the flag state that this cycle's write produces
  assign pend_nx = {periph_req, sw_nx};

  for (genvar g = 0; g < NSRC; g++) begin : g_flat
    assign prio_flat[g*PRIO_W +: PRIO_W] = prio_tab[g];
  end

  // R9
  swflag_set_chk: assert property (@(posedge clk) disable iff (rst)
    sw_we |=> ((sw_q & $past(sw_set)) == $past(sw_set)));

  // R9
  swflag_clr_chk: assert property (@(posedge clk) disable iff (rst)
    sw_we |=> ((sw_q & $past(sw_clr) & ~$past(sw_set)) == '0));
endmodule

// File: rtl/pcic_arbiter.sv
module pcic_arbiter #(
  parameter int NSRC   = 32,
  parameter int PRIO_W = 4,
  localparam int IDX_W = $clog2(NSRC)
) (
  input  logic [NSRC-1:0]        pend,
  input  logic [NSRC*PRIO_W-1:0] prio_flat,
  output logic                   best_valid,
  output logic [PRIO_W-1:0]      best_prio,
  output logic [IDX_W-1:0]       best_idx
);
  // The scan runs from the top index down with >=, so a lower index wins ties
  always_comb begin
    best_prio = '0;
    best_idx  = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (pend[i] && (prio_flat[i*PRIO_W +: PRIO_W] != '0) &&
          (prio_flat[i*PRIO_W +: PRIO_W] >= best_prio)) begin
        best_prio = prio_flat[i*PRIO_W +: PRIO_W];
        best_idx  = IDX_W'(i);
      end
    end
    best_valid = (best_prio != '0);
  end
endmodule

// File: rtl/pcic_prio_stack.sv
module pcic_prio_stack #(
  parameter int DEPTH = 16,
  parameter int W     = 4,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int SPW  = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] top,
  output logic         empty,
  output logic         full
);
  logic [W-1:0]   mem [DEPTH];
  logic [SPW-1:0] sp;
  logic [AW-1:0]  wr_a;
  logic [AW-1:0]  rd_a;

  assign wr_a  = sp[AW-1:0];
  assign rd_a  = AW'(sp - SPW'(1));
  assign empty = (sp == '0);
  assign full  = (sp == SPW'(DEPTH));
  assign top   = mem[rd_a];

  // No reset on the storage, so it can map onto RAM
  always_ff @(posedge clk) begin
    if (push && !full) mem[wr_a] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst)                 sp <= '0;
    else if (push && !full)  sp <= sp + SPW'(1);
    else if (pop && !empty)  sp <= sp - SPW'(1);
  end

  // R10
  stack_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    full |-> !push);

  // R6
  stack_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    empty |-> !pop);

  // R5
  stack_lifo_chk: assert property (@(posedge clk) disable iff (rst)
    (push && !pop) |=> (top == $past(din)));
endmodule

// File: rtl/prio_ceiling_intc.sv
module prio_ceiling_intc
  import pcic_pkg::*;
#(
  parameter int NSW         = 8,
  parameter int NPER        = 24,
  parameter int PRIO_W      = 4,
  parameter int STACK_DEPTH = 16,
  localparam int NSRC       = NSW + NPER,
  localparam int IDX_W      = $clog2(NSRC)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              prio_wr_en,
  input  logic [IDX_W-1:0]  prio_wr_src,
  input  logic [PRIO_W-1:0] prio_wr_level,
  input  logic              swflag_wr_en,
  input  logic [NSW-1:0]    swflag_set,
  input  logic [NSW-1:0]    swflag_clr,
  input  logic [NPER-1:0]   periph_req,
  input  logic              ceil_wr_en,
  input  logic [PRIO_W-1:0] ceil_wr_level,
  input  logic              ack,
  input  logic              eoi,
  output logic              irq_out,
  output logic              ack_valid,
  output logic [IDX_W-1:0]  ack_vec,
  output logic [PRIO_W-1:0] cur_level,
  output logic              eoi_err
);
  logic [NSRC-1:0]        pend_nx;
  logic [NSRC*PRIO_W-1:0] prio_flat;
  logic                   best_valid;
  logic [PRIO_W-1:0]      best_prio;
  logic [IDX_W-1:0]       best_idx;
  logic [PRIO_W-1:0]      cur_q, eff_cur, cur_nx, stk_top;
  logic                   stk_empty, stk_full;
  logic                   irq_q, ack_valid_q, err_q;
  logic [IDX_W-1:0]       ack_vec_q;
  cur_op_e                op;

  pcic_src_regs #(.NSW(NSW), .NPER(NPER), .PRIO_W(PRIO_W)) u_src (
    .clk(clk), .rst(rst),
    .prio_we(prio_wr_en), .prio_idx(prio_wr_src), .prio_wdata(prio_wr_level),
    .sw_we(swflag_wr_en), .sw_set(swflag_set), .sw_clr(swflag_clr),
    .periph_req(periph_req), .pend_nx(pend_nx), .prio_flat(prio_flat)
  );

  pcic_arbiter #(.NSRC(NSRC), .PRIO_W(PRIO_W)) u_arb (
    .pend(pend_nx), .prio_flat(prio_flat),
    .best_valid(best_valid), .best_prio(best_prio), .best_idx(best_idx)
  );

  pcic_prio_stack #(.DEPTH(STACK_DEPTH), .W(PRIO_W)) u_stk (
    .clk(clk), .rst(rst),
    .push(op == OP_TAKE), .pop(op == OP_POP), .din(eff_cur),
    .top(stk_top), .empty(stk_empty), .full(stk_full)
  );

  // A software write lands first, then ack or eoi acts on the result
  always_comb begin
    eff_cur = ceil_wr_en ? ceil_wr_level : cur_q;
    op      = OP_HOLD;
    if (ack) begin
      if (best_valid && (best_prio > eff_cur) && !stk_full) op = OP_TAKE;
    end else if (eoi) begin
      op = stk_empty ? OP_ERR : OP_POP;
    end
    case (op)
      OP_TAKE: cur_nx = best_prio;
      OP_POP:  cur_nx = stk_top;
      default: cur_nx = eff_cur;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q       <= '0;
      irq_q       <= 1'b0;
      ack_valid_q <= 1'b0;
      ack_vec_q   <= '0;
      err_q       <= 1'b0;
    end else begin
      cur_q       <= cur_nx;
      irq_q       <= best_valid && (best_prio > cur_nx);
      ack_valid_q <= (op == OP_TAKE);
      ack_vec_q   <= (op == OP_TAKE) ? best_idx : '0;
      if (op == OP_ERR) err_q <= 1'b1;
    end
  end

  assign irq_out   = irq_q;
  assign ack_valid = ack_valid_q;
  assign ack_vec   = ack_vec_q;
  assign cur_level = cur_q;
  assign eoi_err   = err_q;

  // R4
  take_raise_chk: assert property (@(posedge clk) disable iff (rst)
    (op == OP_TAKE) |=> (ack_valid_q && (cur_q == $past(best_prio))));

  // R6
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    err_q |=> err_q);

  // R7
  ceil_write_chk: assert property (@(posedge clk) disable iff (rst)
    (ceil_wr_en && !ack && !eoi) |=> (cur_q == $past(ceil_wr_level)));

  // R2
  irq_headroom_chk: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> (cur_q != '1));

  // R11
  ack_eoi_chk: assert property (@(posedge clk) disable iff (rst)
    (ack && eoi && !ceil_wr_en) |=> (ack_valid_q || (cur_q == $past(cur_q))));

  // R3
  vec_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !ack_valid_q |-> (ack_vec_q == '0));
endmodule

// File: tb/prio_ceiling_intc_bench.sv
module prio_ceiling_intc_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        d_pw_en = 1'b0;
  logic [4:0]  d_pw_idx = '0;
  logic [3:0]  d_pw_data = '0;
  logic        d_sw_en = 1'b0;
  logic [7:0]  d_sw_set = '0;
  logic [7:0]  d_sw_clr = '0;
  logic [23:0] d_per = '0;
  logic        d_cw_en = 1'b0;
  logic [3:0]  d_cw = '0;
  logic        d_ack = 1'b0;
  logic        d_eoi = 1'b0;
  logic        irq_out, ack_valid, eoi_err;
  logic [4:0]  ack_vec;
  logic [3:0]  cur_level;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Reference state, kept from the requirements
  int         m_prio [32];
  logic [7:0] m_sw;
  int         m_cur;
  int         m_stk [16];
  int         m_sp;
  bit         m_err;
  int         e_irq, e_av, e_vec;

  always #10 clk = ~clk;

  prio_ceiling_intc u_prio_ceiling_intc (
    .clk(clk), .rst(rst),
    .prio_wr_en(d_pw_en), .prio_wr_src(d_pw_idx), .prio_wr_level(d_pw_data),
    .swflag_wr_en(d_sw_en), .swflag_set(d_sw_set), .swflag_clr(d_sw_clr),
    .periph_req(d_per), .ceil_wr_en(d_cw_en), .ceil_wr_level(d_cw),
    .ack(d_ack), .eoi(d_eoi),
    .irq_out(irq_out), .ack_valid(ack_valid), .ack_vec(ack_vec),
    .cur_level(cur_level), .eoi_err(eoi_err)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Drive is already set; predict, wait one edge, compare, clear strobes
  task automatic tick(input string tag);
    logic [7:0]  swn;
    logic [31:0] pend;
    int bp, bi, eff, curn;
    bit take, pop;
    swn  = d_sw_en ? ((m_sw & ~d_sw_clr) | d_sw_set) : m_sw;
    pend = {d_per, swn};
    bp = 0; bi = 0;
    for (int i = 0; i < 32; i++)
      if (pend[i] && m_prio[i] > bp) begin bp = m_prio[i]; bi = i; end
    eff  = d_cw_en ? int'(d_cw) : m_cur;
    take = d_ack && (bp > eff) && (m_sp < 16);
    pop  = !d_ack && d_eoi && (m_sp > 0);
    if (!d_ack && d_eoi && m_sp == 0) m_err = 1'b1;
    curn = eff;
    if (take) begin m_stk[m_sp] = eff; m_sp++; curn = bp; end
    else if (pop) begin m_sp--; curn = m_stk[m_sp]; end
    if (d_pw_en) m_prio[d_pw_idx] = int'(d_pw_data);
    m_sw  = swn;
    m_cur = curn;
    e_irq = (bp > curn) ? 1 : 0;
    e_av  = take ? 1 : 0;
    e_vec = take ? bi : 0;
    @(posedge clk);
    #5;
    chk(tag, "irq_out", int'(irq_out), e_irq);
    chk(tag, "ack_valid", int'(ack_valid), e_av);
    chk(tag, "ack_vec", int'(ack_vec), e_vec);
    chk(tag, "cur_level", int'(cur_level), m_cur);
    chk(tag, "eoi_err", int'(eoi_err), int'(m_err));
    @(negedge clk);
    d_pw_en = 1'b0; d_sw_en = 1'b0; d_sw_set = '0; d_sw_clr = '0;
    d_cw_en = 1'b0; d_ack = 1'b0; d_eoi = 1'b0;
  endtask

  task automatic set_prio(input int src, input int lvl);
    d_pw_en = 1'b1; d_pw_idx = 5'(src); d_pw_data = 4'(lvl);
    tick("R9");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240613));
    for (int i = 0; i < 32; i++) m_prio[i] = 0;
    for (int i = 0; i < 16; i++) m_stk[i] = 0;
    m_sw = '0; m_cur = 0; m_sp = 0; m_err = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #2;
    // R1 reset state
    chk("R1", "irq_out", int'(irq_out), 0);
    chk("R1", "ack_valid", int'(ack_valid), 0);
    chk("R1", "ack_vec", int'(ack_vec), 0);
    chk("R1", "cur_level", int'(cur_level), 0);
    chk("R1", "eoi_err", int'(eoi_err), 0);
    @(negedge clk);
    tick("R1");

    set_prio(3, 5); set_prio(10, 5); set_prio(20, 9); set_prio(31, 1);
    // R2: priority 0 flag 5 never requests
    d_sw_en = 1'b1; d_sw_set = 8'h20; tick("R2");
    chk("R2", "irq prio0", int'(irq_out), 0);
    // R9: set flag 3
    d_sw_en = 1'b1; d_sw_set = 8'h08; tick("R9");
    chk("R2", "irq raised", int'(irq_out), 1);
    d_per[2] = 1'b1; tick("R2");
    // R3 tie between source 3 and source 10 at priority 5
    d_ack = 1'b1; tick("R3");
    chk("R3", "tie vec", int'(ack_vec), 3);
    chk("R4", "raised", int'(cur_level), 5);
    chk("R2", "irq at ceiling", int'(irq_out), 0);
    d_eoi = 1'b1; tick("R5");
    chk("R5", "restored", int'(cur_level), 0);
    // R9 set wins over clear, then clear alone
    d_sw_en = 1'b1; d_sw_set = 8'h08; d_sw_clr = 8'h08; tick("R9");
    d_ack = 1'b1; tick("R9");
    chk("R9", "set wins", int'(ack_vec), 3);
    d_eoi = 1'b1; tick("R5");
    d_sw_en = 1'b1; d_sw_clr = 8'h08; tick("R9");
    d_ack = 1'b1; tick("R3");
    chk("R3", "periph 2 vec", int'(ack_vec), 10);
    d_eoi = 1'b1; tick("R5");
    // R7 ceiling holds 5 off, 9 preempts
    d_cw_en = 1'b1; d_cw = 4'd5; tick("R7");
    chk("R8", "irq dropped", int'(irq_out), 0);
    d_per[12] = 1'b1; tick("R7");
    chk("R7", "above ceiling", int'(irq_out), 1);
    d_per[12] = 1'b0; tick("R7");
    // R8 arrival in the same cycle as a raising write
    d_per[12] = 1'b1; d_cw_en = 1'b1; d_cw = 4'd9; tick("R8");
    chk("R8", "same-cycle arrival", int'(irq_out), 0);
    d_cw_en = 1'b1; d_cw = 4'd0; tick("R8");
    // R12 write plus ack
    d_cw_en = 1'b1; d_cw = 4'd3; d_ack = 1'b1; tick("R12");
    chk("R12", "took", int'(cur_level), 9);
    d_eoi = 1'b1; tick("R12");
    chk("R12", "saved written", int'(cur_level), 3);
    // R11 ack plus eoi
    d_cw_en = 1'b1; d_cw = 4'd9; tick("R11");
    d_ack = 1'b1; d_eoi = 1'b1; tick("R11");
    chk("R11", "no pop", int'(cur_level), 9);
    chk("R11", "no err", int'(eoi_err), 0);
    d_cw_en = 1'b1; d_cw = 4'd0; tick("R11");
    d_ack = 1'b1; d_eoi = 1'b1; tick("R11");
    d_eoi = 1'b1; tick("R5");
    chk("R5", "drained", int'(cur_level), 0);
    // R4 ack with nothing eligible
    d_cw_en = 1'b1; d_cw = 4'd15; tick("R4");
    d_ack = 1'b1; tick("R4");
    chk("R4", "refused", int'(ack_valid), 0);
    chk("R4", "level kept", int'(cur_level), 15);
    d_cw_en = 1'b1; d_cw = 4'd0; tick("R4");
    // R6 empty eoi
    d_eoi = 1'b1; tick("R6");
    chk("R6", "err set", int'(eoi_err), 1);
    tick("R6");
    chk("R6", "err sticky", int'(eoi_err), 1);
    chk("R6", "level kept", int'(cur_level), 0);
    // R10 fill the store with only source 31 (priority 1) pending
    d_per = 24'h800000; d_sw_en = 1'b1; d_sw_clr = 8'hFF; tick("R10");
    for (int k = 0; k < 16; k++) begin
      d_ack = 1'b1; tick("R10");
      chk("R10", "push vec", int'(ack_vec), 31);
      d_cw_en = 1'b1; d_cw = 4'd0; tick("R10");
    end
    d_ack = 1'b1; tick("R10");
    chk("R10", "full refused", int'(ack_valid), 0);
    for (int k = 0; k < 16; k++) begin
      d_eoi = 1'b1; tick("R5");
    end
    // Seeded random mix
    for (int n = 0; n < 3000; n++) begin
      if ($urandom % 8 == 0) d_per[$urandom % 24] ^= 1'b1;
      if ($urandom % 8 == 0) begin
        d_pw_en = 1'b1; d_pw_idx = 5'($urandom); d_pw_data = 4'($urandom);
      end
      if ($urandom % 6 == 0) begin
        d_sw_en = 1'b1; d_sw_set = 8'($urandom) & 8'($urandom);
        d_sw_clr = 8'($urandom);
      end
      if ($urandom % 6 == 0) begin d_cw_en = 1'b1; d_cw = 4'($urandom); end
      d_ack = ($urandom % 4 == 0);
      d_eoi = ($urandom % 5 == 0);
      tick("R2");
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule